// File: doc/BRIEF.md
# Virtual Address Region Classifier

This block sorts every 32-bit virtual address a core issues into one of five fixed areas, selected by the top three address bits. From that area, the privilege bit, the access kind and the translation-enable bit it works out four things. The first is whether the address skips translation. The second is the direct-mapped physical address when it does. The third is whether a user-mode access is refused, and with which error code. The fourth is whether the access may be cached. When an address does need translation, the block raises a request towards an external TLB. It hands that TLB's cacheable bit back to the core unchanged.

The block holds no state. Every output is a combinational function of the current inputs, so the classifier can sit directly in the address-generation path ahead of the TLB lookup stage. Area boundaries follow the top address bits:
- below 0x80000000 is the low user area
- 0x80000000 to 0x9FFFFFFF is the cached direct window
- 0xA0000000 to 0xBFFFFFFF is the uncached direct window
- 0xC0000000 to 0xDFFFFFFF is the kernel mapped area
- 0xE0000000 and above is the control area

Inside the control area, the sub-window 0xE0000000 to 0xE3FFFFFF stays open to user mode.

Top module: `va_region_classifier`

## Requirements
- R1: Addresses 0x80000000 to 0xBFFFFFFF and addresses from 0xE0000000 upward always set `bypass`, whatever `xlat_enable` is, and never raise `tlb_req`.
- R2: In 0x80000000 to 0xBFFFFFFF, `paddr` is `vaddr` with bits 31..29 cleared. In the control area, `paddr` equals `vaddr`.
- R3: With `priv_mode`=0, an address in R1's bypassed ranges that is outside 0xE0000000 to 0xE3FFFFFF gives `addr_err`. For `access_kind` 2'b01 (store) the code is 12'h100. For 2'b00 (load) and 2'b10 (fetch) it is 12'h0E0. On such an error `paddr` and `perm` are zero. With no error, `addr_err` is 12'h000.
- R4: When `xlat_enable`=0, an address outside R1's ranges sets `bypass` and gives `paddr` equal to its low 29 bits. Every error-free bypassed access reports `perm`=3'b111 (bit 2 read, bit 1 write, bit 0 execute).
- R5: With `priv_mode`=1, addresses 0xA0000000 to 0xBFFFFFFF and addresses from 0xE0000000 upward give `cacheable`=0. Addresses 0x80000000 to 0x9FFFFFFF give `cacheable`=1.
- R6: With `priv_mode`=0, any address from 0x80000000 upward gives `cacheable`=0. This holds even when the TLB reports cacheable.
- R7: When `xlat_enable`=1 and the address is outside R1's ranges, `tlb_req`=1, `bypass`=0, `paddr`=0, `perm`=0 and `cacheable` follows `tlb_cacheable`, unless R6 forces it to 0. In every other case, `tlb_cacheable` has no effect on any output.
- R8: With `priv_mode`=1, `addr_err` is never set. `access_kind` 2'b11 is treated as a load.
- R9: All outputs follow input changes within the same clock cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vaddr | input | 32 | Virtual address of the access |
| access_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| priv_mode | input | 1 | 1 = privileged, 0 = user |
| xlat_enable | input | 1 | 1 = address translation switched on |
| tlb_cacheable | input | 1 | Cacheable attribute returned by the external TLB |
| bypass | output | 1 | Address is not translated |
| paddr | output | 32 | Direct-mapped physical address (zero when translated or refused) |
| addr_err | output | 12 | Address-error code, zero when allowed |
| perm | output | 3 | Read/write/execute permission for a bypassed access |
| tlb_req | output | 1 | Request to the external TLB lookup |
| cacheable | output | 1 | Access may be cached |

## Verification
The hardest cases to reach are the ones that sit on the edges of the user-mode store-queue window. The last word at 0xE3FFFFFC and the first word past it at 0xE4000000 must fall on opposite sides of the error decision. The kernel mapped area reached from user mode is also hard, because it is neither bypassed by area nor refused, yet it must still report non-cacheable. The stimulus table puts addresses on both sides of each window boundary. It pairs the same address with translation on and off and with both TLB cacheable values, so that each bit of area decode and each override is seen to flip an output.

// File: rtl/va_region_pkg.sv
package va_region_pkg;

   // Number of top address bits that select an area.
   localparam int AREA_W = 3;

   typedef enum logic [2:0] {
      RG_LOW_USER,
      RG_DIRECT_CACHED,
      RG_DIRECT_UNCACHED,
      RG_KERNEL_MAPPED,
      RG_CONTROL
   } region_e;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_ALT   = 2'b11
   } access_e;

   localparam logic [2:0] PERM_ALL  = 3'b111;
   localparam logic [2:0] PERM_NONE = 3'b000;

endpackage

// File: rtl/vrc_region_decode.sv
module vrc_region_decode
   import va_region_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SQ_TAG_W  = 6
) (
   input  logic [ADDR_W-1:0] vaddr,
   output region_e           region,
   output logic              in_sq_window
);

   localparam int LOW_TAG_W = SQ_TAG_W - AREA_W;

   logic [AREA_W-1:0] area_bits;
   assign area_bits = vaddr[ADDR_W-1 -: AREA_W];

   always_comb begin
      unique casez (area_bits)
         3'b0??:  region = RG_LOW_USER;
         3'b100:  region = RG_DIRECT_CACHED;
         3'b101:  region = RG_DIRECT_UNCACHED;
         3'b110:  region = RG_KERNEL_MAPPED;
         default: region = RG_CONTROL;
      endcase
   end

   generate
      if (LOW_TAG_W > 0) begin : g_sq_sub
         assign in_sq_window = (area_bits == 3'b111) &&
                               (vaddr[ADDR_W-AREA_W-1 -: LOW_TAG_W] == '0);
      end else begin : g_sq_whole
         assign in_sq_window = (area_bits == 3'b111);
      end
   endgenerate

endmodule

// File: rtl/vrc_access_check.sv
module vrc_access_check
   import va_region_pkg::*;
#(
   parameter int              ERR_W    = 12,
   parameter logic [ERR_W-1:0] ERR_READ  = 12'h0E0,
   parameter logic [ERR_W-1:0] ERR_WRITE = 12'h100
) (
   input  region_e           region,
   input  logic              in_sq_window,
   input  logic              priv_mode,
   input  logic [1:0]        access_kind,
   output logic              fault,
   output logic [ERR_W-1:0]  err_code
);

   logic fixed_area;

   always_comb begin
      fixed_area = (region == RG_DIRECT_CACHED) ||
                   (region == RG_DIRECT_UNCACHED) ||
                   (region == RG_CONTROL);
      fault      = !priv_mode && fixed_area && !in_sq_window;
      err_code   = '0;
      if (fault) begin
         if (access_kind == ACC_STORE) err_code = ERR_WRITE;
         else                          err_code = ERR_READ;
      end
   end

endmodule

// File: rtl/vrc_direct_map.sv
module vrc_direct_map
   import va_region_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter bit CTRL_IDENT  = 1'b1
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  region_e           region,
   input  logic              fault,
   input  logic              xlat_enable,
   output logic              bypass,
   output logic [ADDR_W-1:0] paddr,
   output logic [2:0]        perm,
   output logic              tlb_req
);

   localparam int PHYS_W = ADDR_W - AREA_W;

   logic [ADDR_W-1:0] low_pa;
   logic [ADDR_W-1:0] ctrl_pa;

   assign low_pa = {{AREA_W{1'b0}}, vaddr[PHYS_W-1:0]};

   generate
      if (CTRL_IDENT) begin : g_ctrl_ident
         assign ctrl_pa = vaddr;
      end else begin : g_ctrl_masked
         assign ctrl_pa = low_pa;
      end
   endgenerate

   always_comb begin
      bypass  = 1'b0;
      paddr   = '0;
      perm    = PERM_NONE;
      tlb_req = 1'b0;
      if (fault) begin
         bypass = 1'b1;
      end else begin
         unique case (region)
            RG_DIRECT_CACHED, RG_DIRECT_UNCACHED: begin
               bypass = 1'b1;
               paddr  = low_pa;
               perm   = PERM_ALL;
            end
            RG_CONTROL: begin
               bypass = 1'b1;
               paddr  = ctrl_pa;
               perm   = PERM_ALL;
            end
            default: begin
               if (!xlat_enable) begin
                  bypass = 1'b1;
                  paddr  = low_pa;
                  perm   = PERM_ALL;
               end else begin
                  tlb_req = 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/vrc_cache_attr.sv
module vrc_cache_attr
   import va_region_pkg::*;
(
   input  region_e region,
   input  logic    priv_mode,
   input  logic    tlb_req,
   input  logic    tlb_cacheable,
   output logic    cacheable
);

   logic area_blocks;

   always_comb begin
      if (priv_mode)
         area_blocks = (region == RG_DIRECT_UNCACHED) || (region == RG_CONTROL);
      else
         area_blocks = (region != RG_LOW_USER);

      if (area_blocks)  cacheable = 1'b0;
      else if (tlb_req) cacheable = tlb_cacheable;
      else              cacheable = 1'b1;
   end

endmodule

// File: rtl/va_region_classifier.sv
module va_region_classifier
   import va_region_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              SQ_TAG_W   = 6,
   parameter int              ERR_W      = 12,
   parameter logic [ERR_W-1:0] ERR_READ   = 12'h0E0,
   parameter logic [ERR_W-1:0] ERR_WRITE  = 12'h100,
   parameter bit              CTRL_IDENT = 1'b1
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [1:0]        access_kind,
   input  logic              priv_mode,
   input  logic              xlat_enable,
   input  logic              tlb_cacheable,
   output logic              bypass,
   output logic [ADDR_W-1:0] paddr,
   output logic [ERR_W-1:0]  addr_err,
   output logic [2:0]        perm,
   output logic              tlb_req,
   output logic              cacheable
);

   generate
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("ADDR_W must be at least 8");
      end
      if (SQ_TAG_W < AREA_W || SQ_TAG_W > ADDR_W) begin : g_bad_sq_w
         $error("SQ_TAG_W must lie between the area width and ADDR_W");
      end
      if (ERR_READ == '0 || ERR_WRITE == '0) begin : g_bad_codes
         $error("error codes must be non-zero");
      end
   endgenerate

   region_e           region;
   logic              in_sq_window;
   logic              fault;
   logic              map_tlb_req;

   vrc_region_decode #(
      .ADDR_W   (ADDR_W),
      .SQ_TAG_W (SQ_TAG_W)
   ) i_decode (
      .vaddr        (vaddr),
      .region       (region),
      .in_sq_window (in_sq_window)
   );

   vrc_access_check #(
      .ERR_W     (ERR_W),
      .ERR_READ  (ERR_READ),
      .ERR_WRITE (ERR_WRITE)
   ) i_access (
      .region       (region),
      .in_sq_window (in_sq_window),
      .priv_mode    (priv_mode),
      .access_kind  (access_kind),
      .fault        (fault),
      .err_code     (addr_err)
   );

   vrc_direct_map #(
      .ADDR_W     (ADDR_W),
      .CTRL_IDENT (CTRL_IDENT)
   ) i_map (
      .vaddr       (vaddr),
      .region      (region),
      .fault       (fault),
      .xlat_enable (xlat_enable),
      .bypass      (bypass),
      .paddr       (paddr),
      .perm        (perm),
      .tlb_req     (map_tlb_req)
   );

   vrc_cache_attr i_cache (
      .region        (region),
      .priv_mode     (priv_mode),
      .tlb_req       (map_tlb_req),
      .tlb_cacheable (tlb_cacheable),
      .cacheable     (cacheable)
   );

   assign tlb_req = map_tlb_req;

endmodule

// File: rtl/vrc_checker.sv
module vrc_checker #(
   parameter int ADDR_W = 32,
   parameter int ERR_W  = 12
) (
   input logic [ADDR_W-1:0] vaddr,
   input logic              priv_mode,
   input logic              bypass,
   input logic [ADDR_W-1:0] paddr,
   input logic [ERR_W-1:0]  addr_err,
   input logic [2:0]        perm,
   input logic              tlb_req,
   input logic              cacheable
);

   logic fixed_win;
   assign fixed_win = (vaddr[ADDR_W-1 -: 2] == 2'b10) || (vaddr[ADDR_W-1 -: 3] == 3'b111);

   always_comb begin
      if (!$isunknown({vaddr, priv_mode})) begin
         assert_fixed_bypass_R1: assert (!fixed_win || (bypass && !tlb_req))
            else $error("fixed window not bypassed");
         assert_err_quiet_R3: assert (addr_err == '0 ||
                                      (bypass && !tlb_req && !cacheable && perm == 3'b000 && paddr == '0))
            else $error("refused access leaked outputs");
         assert_full_perm_R4: assert (!(bypass && addr_err == '0) || perm == 3'b111)
            else $error("bypass without full permission");
         assert_user_uncached_R6: assert (priv_mode || !vaddr[ADDR_W-1] || !cacheable)
            else $error("user upper half cacheable");
         assert_tlb_excl_R7: assert (!tlb_req || (!bypass && paddr == '0 && perm == 3'b000))
            else $error("tlb request with direct map");
         assert_priv_no_err_R8: assert (!priv_mode || addr_err == '0)
            else $error("privileged access refused");
      end
   end

endmodule

bind va_region_classifier vrc_checker #(
   .ADDR_W (ADDR_W),
   .ERR_W  (ERR_W)
) i_vrc_checker (
   .vaddr     (vaddr),
   .priv_mode (priv_mode),
   .bypass    (bypass),
   .paddr     (paddr),
   .addr_err  (addr_err),
   .perm      (perm),
   .tlb_req   (tlb_req),
   .cacheable (cacheable)
);

// File: tb/test_va_region_classifier.sv
module test_va_region_classifier;

   logic clk = 1'b0;
   logic rst_n;
   always #5 clk = ~clk;

   logic [31:0] vaddr;
   logic [1:0]  access_kind;
   logic        priv_mode, xlat_enable, tlb_cacheable;
   logic        bypass, tlb_req, cacheable;
   logic [31:0] paddr;
   logic [11:0] addr_err;
   logic [2:0]  perm;

   va_region_classifier i_va_region_classifier (
      .vaddr         (vaddr),
      .access_kind   (access_kind),
      .priv_mode     (priv_mode),
      .xlat_enable   (xlat_enable),
      .tlb_cacheable (tlb_cacheable),
      .bypass        (bypass),
      .paddr         (paddr),
      .addr_err      (addr_err),
      .perm          (perm),
      .tlb_req       (tlb_req),
      .cacheable     (cacheable)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [31:0] va;
      logic [1:0]  ak;
      logic        pv;
      logic        xe;
      logic        tc;
      logic        bp;
      logic [31:0] pa;
      logic [11:0] er;
      logic [2:0]  pm;
      logic        rq;
      logic        ch;
   } vec_t;

   localparam int NVEC = 18;
   // req, va, ak, pv, xe, tc | bp, pa, er, pm, rq, ch
   localparam vec_t VECS [NVEC] = '{
      '{4'd2, 32'h8000_1234, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_1234, 12'h000, 3'd7, 1'b0, 1'b1}, // R2 R5 cached window
      '{4'd5, 32'hA123_4560, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0123_4560, 12'h000, 3'd7, 1'b0, 1'b0}, // R5 uncached window
      '{4'd1, 32'hFF00_0010, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 32'hFF00_0010, 12'h000, 3'd7, 1'b0, 1'b0}, // R1 control area
      '{4'd3, 32'h9000_0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 12'h0E0, 3'd0, 1'b0, 1'b0}, // R3 user load
      '{4'd3, 32'h9000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 12'h100, 3'd0, 1'b0, 1'b0}, // R3 user store
      '{4'd3, 32'hE000_0040, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 32'hE000_0040, 12'h000, 3'd7, 1'b0, 1'b0}, // R3 sq window low
      '{4'd3, 32'hE3FF_FFFC, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 32'hE3FF_FFFC, 12'h000, 3'd7, 1'b0, 1'b0}, // R3 sq window top
      '{4'd3, 32'hE400_0000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 12'h0E0, 3'd0, 1'b0, 1'b0}, // R3 past sq, fetch
      '{4'd7, 32'h1234_5678, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 12'h000, 3'd0, 1'b1, 1'b1}, // R7 tlb cached
      '{4'd7, 32'h1234_5678, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 12'h000, 3'd0, 1'b1, 1'b0}, // R7 tlb uncached
      '{4'd4, 32'h1234_5678, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1234_5678, 12'h000, 3'd7, 1'b0, 1'b1}, // R4 xlat off
      '{4'd4, 32'hC765_4321, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0765_4321, 12'h000, 3'd7, 1'b0, 1'b1}, // R4 kernel xlat off
      '{4'd7, 32'hC765_4321, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 12'h000, 3'd0, 1'b1, 1'b0}, // R7 kernel mapped
      '{4'd7, 32'h7FFF_FFFF, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 12'h000, 3'd0, 1'b1, 1'b1}, // R7 top of low area
      '{4'd8, 32'hBFFF_FFFF, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 12'h0E0, 3'd0, 1'b0, 1'b0}, // R8 kind 11 as load
      '{4'd6, 32'hDFFF_FFFF, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1FFF_FFFF, 12'h000, 3'd7, 1'b0, 1'b0}, // R6 user kernel area
      '{4'd6, 32'hC000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 12'h000, 3'd0, 1'b1, 1'b0}, // R6 overrides tlb bit
      '{4'd2, 32'h9FFF_FFFF, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 32'h1FFF_FFFF, 12'h000, 3'd7, 1'b0, 1'b1}  // R2 window top
   };

   int n_tests = 0;
   int n_fail  = 0;

   task automatic apply(input logic [31:0] va, input logic [1:0] ak,
                        input logic pv, input logic xe, input logic tc);
      @(negedge clk);
      vaddr = va; access_kind = ak; priv_mode = pv; xlat_enable = xe; tlb_cacheable = tc;
      #2;
   endtask

   task automatic check(input string tag, input logic bp, input logic [31:0] pa,
                        input logic [11:0] er, input logic [2:0] pm,
                        input logic rq, input logic ch);
      n_tests++;
      if (bypass !== bp || paddr !== pa || addr_err !== er || perm !== pm ||
          tlb_req !== rq || cacheable !== ch) begin
         n_fail++;
         $display("FAIL %s va=%h: got bp=%b pa=%h er=%h pm=%b rq=%b ch=%b, expected bp=%b pa=%h er=%h pm=%b rq=%b ch=%b",
                  tag, vaddr, bypass, paddr, addr_err, perm, tlb_req, cacheable,
                  bp, pa, er, pm, rq, ch);
      end
   endtask

   initial begin : watchdog
      #1_000_000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0;
      vaddr = '0; access_kind = 2'd0; priv_mode = 1'b0; xlat_enable = 1'b0; tlb_cacheable = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      // R4: idle inputs during reset, low user area with translation off
      check("R4 reset", 1'b1, 32'h0, 12'h000, 3'd7, 1'b0, 1'b1);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         apply(VECS[i].va, VECS[i].ak, VECS[i].pv, VECS[i].xe, VECS[i].tc);
         check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].bp, VECS[i].pa,
               VECS[i].er, VECS[i].pm, VECS[i].rq, VECS[i].ch);
      end

      // R7: tlb_cacheable has no effect on a bypassed cached window access
      apply(32'h8000_0040, 2'd0, 1'b1, 1'b1, 1'b0);
      check("R7 ignored tlb bit", 1'b1, 32'h0000_0040, 12'h000, 3'd7, 1'b0, 1'b1);

      // R1: fixed window stays bypassed with translation enabled, user sq store
      apply(32'hE3FF_FFFF, 2'd1, 1'b0, 1'b1, 1'b1);
      check("R1 sq edge xlat on", 1'b1, 32'hE3FF_FFFF, 12'h000, 3'd7, 1'b0, 1'b0);

      // R8: privileged access to area user mode refuses
      apply(32'h9000_0000, 2'd1, 1'b1, 1'b1, 1'b1);
      check("R8 priv no error", 1'b1, 32'h1000_0000, 12'h000, 3'd7, 1'b0, 1'b1);

      // R9: outputs change within the same cycle, before the next edge
      @(negedge clk);
      vaddr = 32'h0000_1000; access_kind = 2'd0; priv_mode = 1'b1; xlat_enable = 1'b1; tlb_cacheable = 1'b1;
      #1;
      check("R9 same cycle a", 1'b0, 32'h0, 12'h000, 3'd0, 1'b1, 1'b1);
      xlat_enable = 1'b0;
      #1;
      check("R9 same cycle b", 1'b1, 32'h0000_1000, 12'h000, 3'd7, 1'b0, 1'b1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule